// File: doc/BRIEF.md
# DMA Channel Completion Control

This block is the per-channel bookkeeping core of a DMA engine. Software programs a transfer size and sets the channel enable bit through a small register write port. The channel then waits for a transfer request. Once a request arrives it marks itself active, and from then on it counts the end-of-cycle handshakes that the bus engine returns.

When the handshake for the last unit arrives, the block finishes the channel in a single clock edge. It drops the active flag, clears the enable bit and raises a completion flag. If interrupts are enabled, the completion flag drives an interrupt request. Writing the enable bit to 1 again re-arms the channel. That write reloads the counter and withdraws the completion flag, so a pending interrupt is cancelled without a separate flag write.

Address generation, the bus protocol and arbitration between channels belong to neighbouring logic.

Top module: `dma_chan_done_ctl`

## Requirements
- R1: After reset the enable bit, active flag, completion flag, interrupt-enable bit, interrupt request, remaining count and size register are all 0.
- R2: A write to the control register (address 0) with bit 0 = 1 while the enable bit is 0 sets the enable bit and loads the remaining count from the size register (address 1, low CNT_W bits). A size write while enabled leaves the remaining count unchanged.
- R3: Each cycle with xfer_done high while the active flag is 1 lowers the remaining count by one. xfer_done while the active flag is 0 leaves the count unchanged.
- R4: The active flag becomes 1 one cycle after xfer_req is seen high while the enable bit is 1. It stays 1 until the last unit completes. While the enable bit is 0, xfer_req has no effect.
- R5: xfer_done while active with a remaining count of 1 makes, on the next cycle, the completion flag 1, the active flag 0, the enable bit 0 and the remaining count 0. A size of 1 completes after a single handshake.
- R6: A programmed size of 0 moves 2^CNT_W units before completion.
- R7: The interrupt request equals the completion flag ANDed with the interrupt-enable bit (control bit 1), and follows changes in the same cycle the registers change.
- R8: A re-arm write (R2) clears the completion flag, and the interrupt request is 0 on the next cycle.
- R9: A control write with bit 2 = 0 clears the completion flag. A control write with bit 2 = 1 leaves the flag as it was.
- R10: A control write with bit 0 = 0 while enabled clears the enable bit and the active flag. The completion flag stays 0 and the remaining count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 size |
| wr_data | input | DATA_W | Write data |
| xfer_req | input | 1 | Transfer request for this channel |
| xfer_done | input | 1 | End of one transfer bus cycle |
| ch_enable | output | 1 | Channel enable bit |
| ch_active | output | 1 | Channel is transferring |
| ch_done | output | 1 | Completion flag |
| ch_irq | output | 1 | Interrupt request |
| ch_count | output | CNT_W | Remaining transfer units |

## Verification
A counter that slips by one shows up as completion one handshake early or late. The error is visible on ch_done and ch_enable in the cycle after the handshake that should have been the last. It also appears at once on ch_count after any handshake. A stuck active or enable flag shows as handshakes that are miscounted or requests that are ignored on the next edge. A completion flag that fails to clear on re-arm keeps ch_irq high on the cycle after the write.

// File: rtl/dma_done_pkg.sv
package dma_done_pkg;
   localparam int unsigned REG_CTRL      = 0;
   localparam int unsigned REG_SIZE      = 1;
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_IE_BIT   = 1;
   localparam int unsigned CTRL_DONE_BIT = 2;

   typedef struct packed {
      logic arm;       // enable 0 -> 1
      logic disarm;    // enable 1 -> 0 by software
      logic ie_wr;
      logic ie_val;
      logic done_clr;
      logic size_wr;
   } ctl_cmd_t;
endpackage

// File: rtl/dma_wr_decode.sv
module dma_wr_decode
   import dma_done_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              en_q,
   output ctl_cmd_t          cmd,
   output logic [CNT_W-1:0]  size_val
);
   logic is_ctrl;
   logic is_size;

   always_comb begin
      is_ctrl      = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
      is_size      = wr_en && (wr_addr == ADDR_W'(REG_SIZE));
      cmd.arm      = is_ctrl && wr_data[CTRL_EN_BIT] && !en_q;
      cmd.disarm   = is_ctrl && !wr_data[CTRL_EN_BIT] && en_q;
      cmd.ie_wr    = is_ctrl;
      cmd.ie_val   = wr_data[CTRL_IE_BIT];
      cmd.done_clr = is_ctrl && !wr_data[CTRL_DONE_BIT];
      cmd.size_wr  = is_size;
      size_val     = wr_data[CNT_W-1:0];
   end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             size_wr,
   input  logic [CNT_W-1:0] size_val,
   input  logic             load,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             last
);
   logic [CNT_W-1:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
      end else if (size_wr) begin
         size_q <= size_val;
      end
   end

   // A size of zero loads zero; the first decrement wraps, giving 2^CNT_W units.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= size_q;
      end else if (dec) begin
         count <= count - 1'b1;
      end
   end

   assign last = (count == CNT_W'(1));
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
   import dma_done_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ctl_cmd_t cmd,
   input  logic     xfer_req,
   input  logic     xfer_done,
   input  logic     last,
   output logic     en_q,
   output logic     active_q,
   output logic     done_q,
   output logic     ie_q
);
   logic finish;

   assign finish = active_q && xfer_done && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         active_q <= 1'b0;
         done_q   <= 1'b0;
         ie_q     <= 1'b0;
      end else begin
         if (finish || cmd.disarm) begin
            en_q <= 1'b0;
         end else if (cmd.arm) begin
            en_q <= 1'b1;
         end

         if (finish || cmd.disarm) begin
            active_q <= 1'b0;
         end else if (en_q && xfer_req) begin
            active_q <= 1'b1;
         end

         if (finish) begin
            done_q <= 1'b1;
         end else if (cmd.arm || cmd.done_clr) begin
            done_q <= 1'b0;
         end

         if (cmd.ie_wr) begin
            ie_q <= cmd.ie_val;
         end
      end
   end
endmodule

// File: rtl/dma_chan_done_ctl.sv
module dma_chan_done_ctl
   import dma_done_pkg::*;
#(
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CNT_W   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer_req,
   input  logic              xfer_done,
   output logic              ch_enable,
   output logic              ch_active,
   output logic              ch_done,
   output logic              ch_irq,
   output logic [CNT_W-1:0]  ch_count
);
   localparam int unsigned CTRL_BITS = CTRL_DONE_BIT + 1;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (DATA_W < CNT_W || DATA_W < CTRL_BITS) begin : g_bad_data
      $error("DATA_W must hold the size field and the control bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   ctl_cmd_t         cmd;
   logic [CNT_W-1:0] size_val;
   logic             last;
   logic             ie_q;
   logic             arm_s;

   assign arm_s = cmd.arm;

   dma_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .en_q     (ch_enable),
      .cmd      (cmd),
      .size_val (size_val)
   );

   dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .size_wr  (cmd.size_wr),
      .size_val (size_val),
      .load     (cmd.arm),
      .dec      (ch_active && xfer_done),
      .count    (ch_count),
      .last     (last)
   );

   dma_chan_flags u_flg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .xfer_req  (xfer_req),
      .xfer_done (xfer_done),
      .last      (last),
      .en_q      (ch_enable),
      .active_q  (ch_active),
      .done_q    (ch_done),
      .ie_q      (ie_q)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ch_irq <= 1'b0;
         end else begin
            ch_irq <= ch_done && ie_q;
         end
      end
   end else begin : g_irq_comb
      assign ch_irq = ch_done && ie_q;
   end
endmodule

// File: rtl/dma_done_chk.sv
module dma_done_chk #(
   parameter int unsigned CNT_W   = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_req,
   input logic             xfer_done,
   input logic             ch_enable,
   input logic             ch_active,
   input logic             ch_done,
   input logic             ch_irq,
   input logic [CNT_W-1:0] ch_count,
   input logic             arm_s
);
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active && xfer_done) |=> (ch_count == CNT_W'($past(ch_count) - 1'b1)));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_active && !arm_s) |=> (ch_count == $past(ch_count)));

   a_r4_active_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      ch_active |-> ch_enable);

   a_r4_no_req_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_active && !xfer_req) |=> !ch_active);

   a_r5_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_active && xfer_done && ch_count == CNT_W'(1)) |=> (ch_done && !ch_active && !ch_enable));

   a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_done) |-> $past(ch_active && xfer_done));

   a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      arm_s |=> !ch_done);

   if (IRQ_REG) begin : g_chk_reg
      a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         ch_irq |-> $past(ch_done));
   end else begin : g_chk_comb
      a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
         ch_irq |-> ch_done);
   end
endmodule

bind dma_chan_done_ctl dma_done_chk #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .xfer_req  (xfer_req),
   .xfer_done (xfer_done),
   .ch_enable (ch_enable),
   .ch_active (ch_active),
   .ch_done   (ch_done),
   .ch_irq    (ch_irq),
   .ch_count  (ch_count),
   .arm_s     (arm_s)
);

// File: tb/sim_dma_chan_done_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_done_ctl;
   localparam int unsigned ADDR_W = 2;
   localparam int unsigned DATA_W = 16;
   localparam int unsigned CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              xfer_req = 1'b0;
   logic              xfer_done = 1'b0;
   logic              ch_enable, ch_active, ch_done, ch_irq;
   logic [CNT_W-1:0]  ch_count;

   int n_chk  = 0;
   int n_fail = 0;
   bit over   = 1'b0;

   always #2 clk = ~clk;

   dma_chan_done_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .xfer_req(xfer_req), .xfer_done(xfer_done), .ch_enable(ch_enable),
      .ch_active(ch_active), .ch_done(ch_done), .ch_irq(ch_irq), .ch_count(ch_count)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Inputs change on the falling edge; results are read on the next falling edge.
   task automatic wr(input int addr, input int data);
      wr_en   = 1'b1;
      wr_addr = ADDR_W'(addr);
      wr_data = DATA_W'(data);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse_done();
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "enable", ch_enable, 0);
      check("R1", "active", ch_active, 0);
      check("R1", "done",   ch_done,   0);
      check("R1", "irq",    ch_irq,    0);
      check("R1", "count",  ch_count,  0);
      // size register must be 0: arming now loads 0
      wr(0, 3'b101);
      check("R1", "count after arm at reset size", ch_count, 0);
      wr(0, 3'b100);
      check("R10", "disarm enable", ch_enable, 0);
   endtask

   task automatic t_basic();
      wr(1, 3);
      wr(0, 3'b111);
      check("R2", "enable after arm", ch_enable, 1);
      check("R2", "count loaded", ch_count, 3);
      check("R4", "active before request", ch_active, 0);
      pulse_done();
      check("R3", "count with inactive handshake", ch_count, 3);
      xfer_req = 1'b1;
      @(negedge clk);
      check("R4", "active after request", ch_active, 1);
      pulse_done();
      check("R3", "count after 1st", ch_count, 2);
      pulse_done();
      check("R3", "count after 2nd", ch_count, 1);
      check("R4", "active before last", ch_active, 1);
      check("R5", "done before last", ch_done, 0);
      pulse_done();
      xfer_req = 1'b0;
      check("R5", "done", ch_done, 1);
      check("R5", "active cleared", ch_active, 0);
      check("R5", "enable cleared", ch_enable, 0);
      check("R5", "count zero", ch_count, 0);
      check("R7", "irq with ie", ch_irq, 1);
   endtask

   task automatic t_irq_mask();
      wr(0, 3'b100);
      check("R7", "irq masked", ch_irq, 0);
      check("R9", "done kept by write of 1", ch_done, 1);
      wr(0, 3'b110);
      check("R7", "irq unmasked", ch_irq, 1);
   endtask

   task automatic t_sw_clear();
      wr(0, 3'b010);
      check("R9", "done cleared by write of 0", ch_done, 0);
      check("R7", "irq after clear", ch_irq, 0);
   endtask

   task automatic t_single_and_rearm();
      xfer_req = 1'b1;
      @(negedge clk);
      check("R4", "request ignored while disabled", ch_active, 0);
      wr(1, 1);
      wr(0, 3'b111);
      @(negedge clk);
      check("R4", "active size 1", ch_active, 1);
      pulse_done();
      xfer_req = 1'b0;
      check("R5", "size 1 done after one", ch_done, 1);
      check("R5", "size 1 enable off", ch_enable, 0);
      wr(1, 2);
      wr(0, 3'b111);
      check("R8", "rearm clears done", ch_done, 0);
      check("R8", "rearm cancels irq", ch_irq, 0);
      check("R2", "rearm reloads", ch_count, 2);
      wr(1, 9);
      check("R2", "size write while enabled", ch_count, 2);
      xfer_req = 1'b1;
      @(negedge clk);
      check("R4", "active again", ch_active, 1);
      wr(0, 3'b110);
      xfer_req = 1'b0;
      check("R10", "abort enable", ch_enable, 0);
      check("R10", "abort active", ch_active, 0);
      check("R10", "abort done", ch_done, 0);
      check("R10", "abort count held", ch_count, 2);
   endtask

   task automatic t_zero_max();
      wr(1, 0);
      wr(0, 3'b111);
      xfer_req = 1'b1;
      @(negedge clk);
      for (int i = 0; i < (1 << CNT_W) - 1; i++) pulse_done();
      check("R6", "count before last", ch_count, 1);
      check("R6", "not done before last", ch_done, 0);
      pulse_done();
      xfer_req = 1'b0;
      check("R6", "done after 2^CNT_W", ch_done, 1);
      check("R6", "enable off", ch_enable, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_irq_mask();
      t_sw_clear();
      t_single_and_rearm();
      t_zero_max();
      if (!over) begin
         over = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!over) begin
         over = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule